// File: doc/BRIEF.md
# MMU Control Register File

This block holds the small set of memory-mapped control and exception registers that sit next to a processor's address translation unit. Nine word registers are available: the translation control word, the three page table entry staging registers (high, low, assist), the translation table base, the exception address, and the trap, exception and interrupt event codes. Each write is trimmed to the bits its register actually implements. Reads return the stored value in the same cycle.

Two side effects drive an external TLB. Writing the control word with its invalidate command bit set produces a one-cycle invalidate strobe. The command bit itself is never stored. Writing the page table entry high register with a new address-space identifier (its low 8 bits) produces a one-cycle flush strobe. A rewrite with the same identifier produces no strobe.

A second input port carries addresses from the cache/TLB array window, a 128 MB region. The block turns a hit in that window into a one-hot select for one of eight array ports. The arrays themselves live outside the block.

Top module: `mmu_ctl_regfile`

## Requirements
- R1: After reset every register reads zero, and `tlb_inval`, `tlb_flush` and `reg_err` are low.
- R2: A write to offset 0 (control word) with bit 2 set drives `tlb_inval` high in the cycle after the write, for one cycle only. The stored word keeps every written bit except bit 2, which always reads zero.
- R3: A write to offset 1 (entry high) whose bits 7:0 differ from the stored bits 7:0 drives `tlb_flush` high in the cycle after the write, for one cycle only.
- R4: A write to offset 1 whose bits 7:0 equal the stored bits 7:0 leaves `tlb_flush` low, and the new word is still stored.
- R5: Offset 3 (entry assist) stores only write bits 3:0. Its upper bits read zero.
- R6: Offsets 6, 7 and 8 (trap code, exception event, interrupt event) store only write bits 10:0. Their upper bits read zero.
- R7: Offsets 2, 4 and 5 (entry low, table base, exception address) store all 32 written bits.
- R8: A read or write at an offset of 9 or above raises `reg_err` in the same cycle, and a read there returns zero.
- R9: A write at an offset of 9 or above changes no register and produces no strobe.
- R10: When `win_valid` is high and `win_addr[31:27]` equals the window base, `win_hit` is high and `win_sel` has exactly the bit numbered by `win_addr[26:24]` set. The order is: 0 instruction-cache tags, 1 instruction-cache data, 2 instruction TLB tags, 3 instruction TLB data, 4 operand-cache tags, 5 operand-cache data, 6 unified TLB tags, 7 unified TLB data.
- R11: When `win_valid` is low, or the address lies outside the window, `win_hit` is low and `win_sel` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | 4 | Word offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, same cycle as `reg_rd` |
| reg_err | output | 1 | Access to an unmapped offset |
| tlb_inval | output | 1 | One-cycle TLB invalidate strobe |
| tlb_flush | output | 1 | One-cycle flush strobe on identifier change |
| win_valid | input | 1 | Window address qualifier |
| win_addr | input | 32 | Address presented to the array window |
| win_hit | output | 1 | Address falls inside the window |
| win_sel | output | 8 | One-hot array select |

## Verification
The bench first writes all ones to the control word. A design that stored the command bit would read back bit 2 set. A design that dropped the strobe, or held it for more than one cycle, would fail the strobe samples taken one and two cycles later.

The identifier compare is tested in two ways. A rewrite with an unchanged low byte but different upper bits must not flush, which catches a whole-word compare. A change of the low byte must flush.

Masked registers are written with all ones, which exposes an off-by-one width. Unmapped offsets are read, and written with nonzero data, to expose an aliased decode. Window addresses at both ends of the select field, and just outside the window, catch reversed select order and a wrong base compare.

// File: rtl/mmu_rf_pkg.sv
package mmu_rf_pkg;
  localparam int DW        = 32;
  localparam int AW        = 4;
  localparam int NREG      = 9;
  localparam int INVAL_BIT = 2;
  localparam int ASID_W    = 8;
  localparam int AUX_W     = 4;
  localparam int EVT_W     = 11;

  typedef enum logic [AW-1:0] {
    RG_CTRL    = 4'd0,
    RG_PTE_HI  = 4'd1,
    RG_PTE_LO  = 4'd2,
    RG_PTE_AUX = 4'd3,
    RG_TBASE   = 4'd4,
    RG_EXC_ADR = 4'd5,
    RG_TRAP    = 4'd6,
    RG_EXC_EVT = 4'd7,
    RG_INT_EVT = 4'd8
  } reg_id_e;

  // Ones in the low w bits.
  function automatic logic [DW-1:0] low_ones(input int w);
    if (w >= DW) return '1;
    return (DW'(1) << w) - DW'(1);
  endfunction

  // Bits each register actually keeps on a write.
  function automatic logic [DW-1:0] keep_mask(input int idx);
    case (idx)
      int'(RG_CTRL):    return ~(DW'(1) << INVAL_BIT);
      int'(RG_PTE_AUX): return low_ones(AUX_W);
      int'(RG_TRAP),
      int'(RG_EXC_EVT),
      int'(RG_INT_EVT): return low_ones(EVT_W);
      default:          return '1;
    endcase
  endfunction
endpackage

// File: rtl/mmu_rf_decode.sv
module mmu_rf_decode
  import mmu_rf_pkg::*;
#(
  parameter int N_REG  = NREG,
  parameter int ADDR_W = AW
) (
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [N_REG-1:0]  sel,
  output logic              mapped,
  output logic              bad_access
);
  always_comb begin
    mapped = (int'(acc_addr) < N_REG);
    sel    = mapped ? (N_REG'(1) << acc_addr) : '0;
    bad_access = (acc_rd | acc_wr) & ~mapped;
  end
endmodule

// File: rtl/mmu_rf_bank.sv
module mmu_rf_bank
  import mmu_rf_pkg::*;
#(
  parameter int N_REG  = NREG,
  parameter int DATA_W = DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [N_REG-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              inval_pulse,
  output logic              flush_pulse
);
  localparam int CTRL_IX = int'(RG_CTRL);
  localparam int PTEH_IX = int'(RG_PTE_HI);

  logic [DATA_W-1:0] regs [N_REG];

  // Named internal events.
  logic ctrl_wr_inval;
  logic pteh_wr;
  logic asid_change;
  logic asid_same;

  assign ctrl_wr_inval = wr_en & sel[CTRL_IX] & wdata[INVAL_BIT];
  assign pteh_wr       = wr_en & sel[PTEH_IX];
  assign asid_change   = pteh_wr & (wdata[ASID_W-1:0] != regs[PTEH_IX][ASID_W-1:0]);
  assign asid_same     = pteh_wr & (wdata[ASID_W-1:0] == regs[PTEH_IX][ASID_W-1:0]);

  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    localparam logic [DATA_W-1:0] KEEP = DATA_W'(keep_mask(g));
    always_ff @(posedge clk) begin
      if (!rst_n) regs[g] <= '0;
      else if (wr_en && sel[g]) regs[g] <= wdata & KEEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inval_pulse <= 1'b0;
      flush_pulse <= 1'b0;
    end else begin
      inval_pulse <= ctrl_wr_inval;
      flush_pulse <= asid_change;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_REG; i++)
      if (rd_en && sel[i]) rdata = rdata | regs[i];
  end

  a_r2_inval_next: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_inval |=> inval_pulse);
  a_r2_inval_single: assert property (@(posedge clk) disable iff (!rst_n)
    (inval_pulse && !ctrl_wr_inval) |=> !inval_pulse);
  a_r3_flush_next: assert property (@(posedge clk) disable iff (!rst_n)
    asid_change |=> flush_pulse);
  a_r4_no_flush_same: assert property (@(posedge clk) disable iff (!rst_n)
    asid_same |=> !flush_pulse);
endmodule

// File: rtl/mmu_rf_window.sv
module mmu_rf_window #(
  parameter int          ADDR_W   = 32,
  parameter int          SEL_LSB  = 24,
  parameter int          SEL_W    = 3,
  parameter logic [31:0] WIN_BASE = 32'hF000_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                a_valid,
  input  logic [ADDR_W-1:0]   a_addr,
  output logic                hit,
  output logic [(1<<SEL_W)-1:0] onehot
);
  localparam int TOP_LSB = SEL_LSB + SEL_W;
  localparam int N_ARR   = 1 << SEL_W;

  logic [SEL_W-1:0] arr_idx;
  logic             base_match;

  assign arr_idx    = a_addr[TOP_LSB-1:SEL_LSB];
  assign base_match = (a_addr[ADDR_W-1:TOP_LSB] == WIN_BASE[ADDR_W-1:TOP_LSB]);
  assign hit        = a_valid & base_match;
  assign onehot     = hit ? (N_ARR'(1) << arr_idx) : '0;

  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $onehot(onehot));
  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !a_valid |-> (onehot == '0));
endmodule

// File: rtl/mmu_ctl_regfile.sv
module mmu_ctl_regfile
  import mmu_rf_pkg::*;
#(
  parameter logic [31:0] WIN_BASE = 32'hF000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          reg_err,
  output logic          tlb_inval,
  output logic          tlb_flush,
  input  logic          win_valid,
  input  logic [31:0]   win_addr,
  output logic          win_hit,
  output logic [7:0]    win_sel
);
  logic [NREG-1:0] sel;
  logic            mapped;

  mmu_rf_decode #(.N_REG(NREG), .ADDR_W(AW)) u_dec (
    .acc_rd(reg_rd), .acc_wr(reg_wr), .acc_addr(reg_addr),
    .sel(sel), .mapped(mapped), .bad_access(reg_err)
  );

  mmu_rf_bank #(.N_REG(NREG), .DATA_W(DW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd), .sel(sel),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .inval_pulse(tlb_inval), .flush_pulse(tlb_flush)
  );

  mmu_rf_window #(.ADDR_W(32), .SEL_LSB(24), .SEL_W(3), .WIN_BASE(WIN_BASE)) u_win (
    .clk(clk), .rst_n(rst_n), .a_valid(win_valid), .a_addr(win_addr),
    .hit(win_hit), .onehot(win_sel)
  );

  a_r8_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_err && reg_rd) |-> (reg_rdata == '0));
  a_r5_aux_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == RG_PTE_AUX) |-> (reg_rdata[DW-1:AUX_W] == '0));
  a_r6_evt_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr == RG_TRAP || reg_addr == RG_EXC_EVT || reg_addr == RG_INT_EVT))
      |-> (reg_rdata[DW-1:EVT_W] == '0));
  a_r2_ctrl_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == RG_CTRL) |-> !reg_rdata[INVAL_BIT]);
  a_r9_no_strobe_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !mapped) |=> (!tlb_inval && !tlb_flush));
endmodule

// File: tb/mmu_ctl_regfile_bench.sv
module mmu_ctl_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_err, tlb_inval, tlb_flush;
  logic        win_valid = 1'b0;
  logic [31:0] win_addr = '0;
  logic        win_hit;
  logic [7:0]  win_sel;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  mmu_ctl_regfile u_mmu_ctl_regfile (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_err(reg_err), .tlb_inval(tlb_inval), .tlb_flush(tlb_flush),
    .win_valid(win_valid), .win_addr(win_addr), .win_hit(win_hit), .win_sel(win_sel)
  );

  // {offset, write data, expected readback, expected inval, expected flush}
  localparam int NV = 12;
  localparam logic [69:0] VEC [NV] = '{
    {4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFB, 1'b1, 1'b0}, // R2
    {4'd0, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0}, // R2 no command
    {4'd1, 32'h1234_5600, 32'h1234_5600, 1'b0, 1'b0}, // R4 low byte 00 unchanged
    {4'd1, 32'hABCD_EF42, 32'hABCD_EF42, 1'b0, 1'b1}, // R3
    {4'd1, 32'h0000_0042, 32'h0000_0042, 1'b0, 1'b0}, // R4
    {4'd2, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0, 1'b0}, // R7
    {4'd3, 32'hFFFF_FFFF, 32'h0000_000F, 1'b0, 1'b0}, // R5
    {4'd4, 32'h8765_4321, 32'h8765_4321, 1'b0, 1'b0}, // R7
    {4'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0}, // R7
    {4'd6, 32'hFFFF_FFFF, 32'h0000_07FF, 1'b0, 1'b0}, // R6
    {4'd7, 32'h0000_1ABC, 32'h0000_02BC, 1'b0, 1'b0}, // R6
    {4'd8, 32'hFFFF_F800, 32'h0000_0000, 1'b0, 1'b0}  // R6
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp,
                        input logic exp_err);
    reg_rd = 1'b1; reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
    chk({tag, " err"}, 32'(reg_err), 32'(exp_err));
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic win_chk(input string tag, input logic v, input logic [31:0] a,
                         input logic [7:0] exp);
    win_valid = v; win_addr = a;
    #1;
    chk(tag, 32'(win_sel), 32'(exp));
    chk({tag, " hit"}, 32'(win_hit), 32'(exp != 8'h00));
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 inval", 32'(tlb_inval), 0);
    chk("R1 flush", 32'(tlb_flush), 0);
    chk("R1 err", 32'(reg_err), 0);
    for (int i = 0; i < 9; i++) rd_chk("R1 reg", 4'(i), 32'h0, 1'b0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][69:66], VEC[i][65:34]);
      chk($sformatf("R2 inval vec%0d", i), 32'(tlb_inval), 32'(VEC[i][1]));
      chk($sformatf("R3 flush vec%0d", i), 32'(tlb_flush), 32'(VEC[i][0]));
      rd_chk($sformatf("R5 R6 R7 readback vec%0d", i), VEC[i][69:66], VEC[i][33:2], 1'b0);
      chk($sformatf("R2 inval single vec%0d", i), 32'(tlb_inval), 0);
      chk($sformatf("R3 flush single vec%0d", i), 32'(tlb_flush), 0);
    end

    // R8 unmapped reads
    rd_chk("R8 off9", 4'd9, 32'h0, 1'b1);
    rd_chk("R8 off15", 4'd15, 32'h0, 1'b1);
    // R8 write error flag, R9 no effect
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'd12; reg_wdata = 32'hFFFF_FF05;
    #1;
    chk("R8 write err", 32'(reg_err), 1);
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R9 no inval", 32'(tlb_inval), 0);
    chk("R9 no flush", 32'(tlb_flush), 0);
    for (int i = 0; i < NV; i++)
      if (i != 0 && i != 2 && i != 3)
        rd_chk("R9 regs unchanged", VEC[i][69:66], VEC[i][33:2], 1'b0);

    // R10 window selects
    win_chk("R10 icache tags", 1'b1, 32'hF000_0000, 8'h01);
    win_chk("R10 itlb data", 1'b1, 32'hF300_1234, 8'h08);
    win_chk("R10 ocache data", 1'b1, 32'hF5FF_FFFC, 8'h20);
    win_chk("R10 utlb data", 1'b1, 32'hF7FF_FFFF, 8'h80);
    // R11 outside / idle
    win_chk("R11 above", 1'b1, 32'hF800_0000, 8'h00);
    win_chk("R11 below", 1'b1, 32'hEFFF_FFFF, 8'h00);
    win_chk("R11 invalid", 1'b0, 32'hF400_0000, 8'h00);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk("R1 ctrl after reset", 4'd0, 32'h0, 1'b0);
    rd_chk("R1 tbase after reset", 4'd4, 32'h0, 1'b0);
    // R3 after reset, low byte 00 is the stored identifier
    wr(4'd1, 32'h0000_0001);
    chk("R3 flush after reset", 32'(tlb_flush), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule